// File: doc/BRIEF.md
# Noise Source Health Monitor

This block sits beside a raw noise source and its conditioning stage and decides, sample by sample, whether the source can be trusted. Each accepted 8-bit raw sample goes to two statistical tests. The first test looks for runs of identical values. The second test counts how often the first value of a fixed-size window comes back inside that window. A third check compares each conditioned output word with the word accepted just before it.

After reset the monitor is in a startup phase. It releases nothing until a fixed number of samples has passed every test. After that it keeps running the same tests. The first failure of any kind moves the monitor into a fault state and stores a code that names the failing test. Only a reset leaves the fault state, and the startup phase then runs again. Downstream logic should take conditioned output only while `healthy` is high.

The repetition cutoff is derived from the claimed min-entropy, which is 6.31 bits per sample, given in hundredths of a bit. With the default the cutoff is 5. The window length is 512, the proportion cutoff is 13 and the startup length is 1024 samples. All of these are parameters.

Top module: `entropy_health_monitor`

## Requirements
- R1: While reset is held and after it is released, `healthy`, `startupDone` and `errFlag` are 0 and `errCode` is 8'h00.
- R2: When REP_CUTOFF (default 5) accepted samples in a row carry the same value, `errFlag` rises and `errCode` becomes 8'h2C. Both show one cycle after the clock edge that takes the last sample of the run. A run of REP_CUTOFF-1 identical samples raises no fault.
- R3: Each proportion window is APT_WINDOW (default 512) accepted samples long, and its first sample is the reference. If the reference value occurs APT_CUTOFF (default 13) times inside the window, counting the reference itself, the code becomes 8'h2D. An occurrence count of 12 raises no fault. The count restarts with each new window.
- R4: An accepted output word that equals the previously accepted word gives code 8'h1E. The first word after a reset is never flagged, whatever its value. Words are compared during startup as well as in normal operation.
- R5: `startupDone` rises on the cycle after the STARTUP_SAMPLES-th (default 1024) accepted sample, provided no fault has occurred. It stays high until reset. `healthy` is high exactly when `startupDone` is 1 and `errFlag` is 0.
- R6: After startup the same tests run on every sample. A failure in normal operation drops `healthy` to 0 and leaves `startupDone` at 1.
- R7: In the fault state, samples and words are ignored, and the stored code keeps the value of the first failure.
- R8: Only reset clears the fault state. After reset the full startup phase is needed again before `healthy` rises.
- R9: When several tests fail on the same cycle, the stored code follows the priority 8'h2C, then 8'h2D, then 8'h1E.
- R10: A cycle with `sampleValid` low is ignored by both noise tests, whatever `sampleData` holds. It neither breaks a run nor advances a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| sampleValid | input | 1 | Raw sample present this cycle |
| sampleData | input | SAMPLE_W | Raw noise sample |
| wordValid | input | 1 | Conditioned output word present this cycle |
| wordData | input | WORD_W | Conditioned output word |
| healthy | output | 1 | Startup passed and no fault |
| startupDone | output | 1 | Startup phase completed since reset |
| errFlag | output | 1 | Fault state latched |
| errCode | output | 8 | Code of the first failure, 8'h00 when no fault |

## Verification
The run test is driven with runs just below and exactly at the cutoff. One run is split by idle cycles that carry different data, which shows whether invalid cycles are truly ignored. The proportion test gets alternating streams that bring the reference to 12 and to 13 occurrences, and a full window of filler followed by a second window, which separates a count that restarts per window from one that accumulates. The word check gets a first word of zero, which equals a cleared register, a distinct sequence and a repeat at several positions. Coincident failures show the priority order.

// File: rtl/entmon_pkg.sv
package entmon_pkg;

  typedef enum logic [7:0] {
    ERR_NONE        = 8'h00,
    ERR_WORD_REPEAT = 8'h1E,
    ERR_REP_COUNT   = 8'h2C,
    ERR_PROPORTION  = 8'h2D
  } errCode_e;

  typedef enum logic [1:0] {
    ST_STARTUP = 2'd0,
    ST_RUN     = 2'd1,
    ST_FAULT   = 2'd2
  } monState_e;

  // control -> datapath
  typedef struct packed {
    logic sampleEn;
    logic wordEn;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic repFail;
    logic aptFail;
    logic wordFail;
    logic startupLast;
  } dpStatus_t;

endpackage

// File: rtl/entmon_rep_test.sv
module entmon_rep_test #(
  parameter int SAMPLE_W   = 8,
  parameter int REP_CUTOFF = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                en,
  input  logic [SAMPLE_W-1:0] data,
  output logic                fail
);
  localparam int RUN_W = $clog2(REP_CUTOFF + 1);

  logic [SAMPLE_W-1:0] lastSample;
  logic [RUN_W-1:0]    runLen;
  logic                seen;
  logic                isRepeat;

  assign isRepeat = seen && (data == lastSample);
  // the incoming sample would make the run REP_CUTOFF long
  assign fail = en && isRepeat && (runLen == RUN_W'(REP_CUTOFF - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSample <= '0;
      runLen     <= '0;
      seen       <= 1'b0;
    end else if (en) begin
      lastSample <= data;
      seen       <= 1'b1;
      runLen     <= isRepeat ? runLen + RUN_W'(1) : RUN_W'(1);
    end
  end
endmodule

// File: rtl/entmon_prop_test.sv
module entmon_prop_test #(
  parameter int SAMPLE_W   = 8,
  parameter int APT_WINDOW = 512,
  parameter int APT_CUTOFF = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                en,
  input  logic [SAMPLE_W-1:0] data,
  output logic                fail
);
  localparam int IDX_W = $clog2(APT_WINDOW);
  localparam int CNT_W = $clog2(APT_CUTOFF + 1);

  logic [SAMPLE_W-1:0] refSample;
  logic [IDX_W-1:0]    winIdx;
  logic [CNT_W-1:0]    hitCount;
  logic                winStart;
  logic                hit;
  logic                winLast;

  assign winStart = (winIdx == '0);
  assign winLast  = (winIdx == IDX_W'(APT_WINDOW - 1));
  assign hit      = !winStart && (data == refSample);
  assign fail     = en && hit && (hitCount == CNT_W'(APT_CUTOFF - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refSample <= '0;
      winIdx    <= '0;
      hitCount  <= '0;
    end else if (en) begin
      if (winStart) begin
        refSample <= data;
        hitCount  <= CNT_W'(1);
        winIdx    <= IDX_W'(1);
      end else begin
        if (hit) hitCount <= hitCount + CNT_W'(1);
        winIdx <= winLast ? '0 : winIdx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/entmon_datapath.sv
module entmon_datapath
  import entmon_pkg::*;
#(
  parameter int SAMPLE_W        = 8,
  parameter int WORD_W          = 32,
  parameter int REP_CUTOFF      = 5,
  parameter int APT_WINDOW      = 512,
  parameter int APT_CUTOFF      = 13,
  parameter int STARTUP_SAMPLES = 1024
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [WORD_W-1:0]   wordData,
  output dpStatus_t           status
);
  localparam int SCNT_W = $clog2(STARTUP_SAMPLES + 1);

  logic repFail;
  logic aptFail;

  entmon_rep_test #(
    .SAMPLE_W  (SAMPLE_W),
    .REP_CUTOFF(REP_CUTOFF)
  ) u_rep (
    .clk (clk),
    .rstN(rstN),
    .en  (strobe.sampleEn),
    .data(sampleData),
    .fail(repFail)
  );

  entmon_prop_test #(
    .SAMPLE_W  (SAMPLE_W),
    .APT_WINDOW(APT_WINDOW),
    .APT_CUTOFF(APT_CUTOFF)
  ) u_prop (
    .clk (clk),
    .rstN(rstN),
    .en  (strobe.sampleEn),
    .data(sampleData),
    .fail(aptFail)
  );

  // repeated output word comparison
  logic [WORD_W-1:0] prevWord;
  logic              havePrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWord <= '0;
      havePrev <= 1'b0;
    end else if (strobe.wordEn) begin
      prevWord <= wordData;
      havePrev <= 1'b1;
    end
  end

  // startup sample counter, saturates at STARTUP_SAMPLES
  logic [SCNT_W-1:0] sampleCount;
  logic              countFull;

  assign countFull = (sampleCount == SCNT_W'(STARTUP_SAMPLES));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCount <= '0;
    end else if (strobe.sampleEn && !countFull) begin
      sampleCount <= sampleCount + SCNT_W'(1);
    end
  end

  always_comb begin
    status.repFail     = repFail;
    status.aptFail     = aptFail;
    status.wordFail    = strobe.wordEn && havePrev && (wordData == prevWord);
    status.startupLast = strobe.sampleEn &&
                         (sampleCount == SCNT_W'(STARTUP_SAMPLES - 1));
  end
endmodule

// File: rtl/entmon_control.sv
module entmon_control
  import entmon_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleValid,
  input  logic      wordValid,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      healthy,
  output logic      startupDone,
  output logic      errFlag,
  output logic [7:0] errCode
);
  monState_e state;
  errCode_e  codeQ;
  logic      doneQ;
  logic      anyFail;
  errCode_e  failCode;

  always_comb begin
    strobe.sampleEn = sampleValid && (state != ST_FAULT);
    strobe.wordEn   = wordValid   && (state != ST_FAULT);
  end

  // fixed priority among coincident failures
  always_comb begin
    anyFail  = status.repFail || status.aptFail || status.wordFail;
    failCode = ERR_NONE;
    if (status.repFail)       failCode = ERR_REP_COUNT;
    else if (status.aptFail)  failCode = ERR_PROPORTION;
    else if (status.wordFail) failCode = ERR_WORD_REPEAT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_STARTUP;
      codeQ <= ERR_NONE;
      doneQ <= 1'b0;
    end else if (state != ST_FAULT) begin
      if (anyFail) begin
        state <= ST_FAULT;
        codeQ <= failCode;
      end else if (state == ST_STARTUP && status.startupLast) begin
        state <= ST_RUN;
        doneQ <= 1'b1;
      end
    end
  end

  assign healthy     = (state == ST_RUN);
  assign startupDone = doneQ;
  assign errFlag     = (state == ST_FAULT);
  assign errCode     = codeQ;
endmodule

// File: rtl/entropy_health_monitor.sv
module entropy_health_monitor
  import entmon_pkg::*;
#(
  parameter int SAMPLE_W           = 8,
  parameter int WORD_W             = 32,
  parameter int ENTROPY_CENTIBITS  = 631,
  parameter int REP_CUTOFF         = 1 + (2000 + ENTROPY_CENTIBITS - 1) / ENTROPY_CENTIBITS,
  parameter int APT_WINDOW         = 512,
  parameter int APT_CUTOFF         = 13,
  parameter int STARTUP_SAMPLES    = 1024
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                wordValid,
  input  logic [WORD_W-1:0]   wordData,
  output logic                healthy,
  output logic                startupDone,
  output logic                errFlag,
  output logic [7:0]          errCode
);
  dpStrobe_t strobe;
  dpStatus_t status;

  entmon_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .wordValid  (wordValid),
    .status     (status),
    .strobe     (strobe),
    .healthy    (healthy),
    .startupDone(startupDone),
    .errFlag    (errFlag),
    .errCode    (errCode)
  );

  entmon_datapath #(
    .SAMPLE_W       (SAMPLE_W),
    .WORD_W         (WORD_W),
    .REP_CUTOFF     (REP_CUTOFF),
    .APT_WINDOW     (APT_WINDOW),
    .APT_CUTOFF     (APT_CUTOFF),
    .STARTUP_SAMPLES(STARTUP_SAMPLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sampleData(sampleData),
    .wordData  (wordData),
    .status    (status)
  );
endmodule

// File: rtl/entmon_checker.sv
module entmon_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sampleValid,
  input logic       wordValid,
  input logic       healthy,
  input logic       startupDone,
  input logic       errFlag,
  input logic [7:0] errCode
);
  logic seenWord;

  always_ff @(posedge clk) begin
    if (!rstN)          seenWord <= 1'b0;
    else if (wordValid) seenWord <= 1'b1;
  end

  // R5: healthy only after startup and without fault
  p_healthy_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    healthy |-> (startupDone && !errFlag));

  // R5: startup completion is kept until reset
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    startupDone |=> startupDone);

  // R8: fault is latched with a stable code (R7)
  p_fault_latched_r8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> (errFlag && $stable(errCode)));

  // R1: no code without a fault
  p_code_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    !errFlag |-> (errCode == 8'h00));

  // R7: only defined codes are reported
  p_code_legal_r7: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (errCode == 8'h2C || errCode == 8'h2D || errCode == 8'h1E));

  // R4: first word after reset alone never raises a fault
  p_first_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !seenWord && !sampleValid && !errFlag) |=> !errFlag);
endmodule

bind entropy_health_monitor entmon_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .wordValid  (wordValid),
  .healthy    (healthy),
  .startupDone(startupDone),
  .errFlag    (errFlag),
  .errCode    (errCode)
);

// File: tb/entropy_health_monitor_tb.sv
`timescale 1ns/1ps
module entropy_health_monitor_tb;
  localparam int CLK_HALF = 4;  // 125 MHz

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [7:0]  sampleData = '0;
  logic        wordValid = 1'b0;
  logic [31:0] wordData = '0;
  logic        healthy, startupDone, errFlag;
  logic [7:0]  errCode;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  always #CLK_HALF clk = ~clk;

  entropy_health_monitor u_dut (
    .clk(clk), .rstN(rstN),
    .sampleValid(sampleValid), .sampleData(sampleData),
    .wordValid(wordValid), .wordData(wordData),
    .healthy(healthy), .startupDone(startupDone),
    .errFlag(errFlag), .errCode(errCode)
  );

  // scenario table: {kind, n, expErr, expCode}
  // kind 0: run of n equal samples; 1: reference reaching n occurrences;
  // kind 2: n distinct words starting at 0; 3: n words, last repeats previous
  localparam int NSCEN = 9;
  localparam logic [18:0] SCEN [NSCEN] = '{
    {2'd0, 8'd4,  1'b0, 8'h00},
    {2'd0, 8'd5,  1'b1, 8'h2C},
    {2'd0, 8'd1,  1'b0, 8'h00},
    {2'd1, 8'd12, 1'b0, 8'h00},
    {2'd1, 8'd13, 1'b1, 8'h2D},
    {2'd2, 8'd1,  1'b0, 8'h00},
    {2'd2, 8'd6,  1'b0, 8'h00},
    {2'd3, 8'd2,  1'b1, 8'h1E},
    {2'd3, 8'd5,  1'b1, 8'h1E}
  };

  function automatic logic [7:0] good(input int i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sampleValid = 1'b0; wordValid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic pushSample(input logic [7:0] d);
    @(negedge clk);
    sampleValid = 1'b1; sampleData = d;
    @(posedge clk); #1 sampleValid = 1'b0;
  endtask

  task automatic pushWord(input logic [31:0] w);
    @(negedge clk);
    wordValid = 1'b1; wordData = w;
    @(posedge clk); #1 wordValid = 1'b0;
  endtask

  task automatic pushBoth(input logic [7:0] d, input logic [31:0] w);
    @(negedge clk);
    sampleValid = 1'b1; sampleData = d; wordValid = 1'b1; wordData = w;
    @(posedge clk); #1 begin sampleValid = 1'b0; wordValid = 1'b0; end
  endtask

  task automatic startup(input int n);
    for (int i = 0; i < n; i++) pushSample(good(i));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    #(200000 * 2 * CLK_HALF);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: during and after reset
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 check("R1 errFlag in reset", 32'(errFlag), 0);
    doReset();
    check("R1 healthy", 32'(healthy), 0);
    check("R1 startupDone", 32'(startupDone), 0);
    check("R1 errFlag", 32'(errFlag), 0);
    check("R1 errCode", 32'(errCode), 0);

    // table walk: R2, R3, R4
    for (int s = 0; s < NSCEN; s++) begin
      logic [1:0] kind;
      int n;
      kind = SCEN[s][18:17];
      n    = int'(SCEN[s][16:9]);
      doReset();
      case (kind)
        2'd0: for (int k = 0; k < n; k++) pushSample(8'h5A);
        2'd1: begin
          pushSample(8'h01);
          for (int k = 0; k < n - 1; k++) begin
            pushSample(8'h80 | 8'(k));
            pushSample(8'h01);
          end
        end
        2'd2: for (int k = 0; k < n; k++) pushWord(32'(k) * 32'h01010101);
        default: begin
          for (int k = 0; k < n - 1; k++) pushWord(32'h1000 + 32'(k));
          pushWord(32'h1000 + 32'(n - 2));
        end
      endcase
      check($sformatf("R2/R3/R4 scenario %0d errFlag", s), 32'(errFlag), 32'(SCEN[s][8]));
      check($sformatf("R2/R3/R4 scenario %0d errCode", s), 32'(errCode), 32'(SCEN[s][7:0]));
    end

    // R3: count restarts at a new window
    doReset();
    pushSample(8'h01);
    for (int k = 0; k < 11; k++) begin pushSample(8'h80 | 8'(k)); pushSample(8'h01); end
    for (int i = 0; i < 512 - 23; i++) pushSample(8'h80 | 8'(i & 8'h7F));
    pushSample(8'h01);
    for (int k = 0; k < 11; k++) begin pushSample(8'h80 | 8'(k)); pushSample(8'h01); end
    check("R3 second window 12 hits", 32'(errFlag), 0);
    pushSample(8'h8B); pushSample(8'h01);
    check("R3 second window 13 hits", 32'(errCode), 32'h2D);

    // R10: idle cycles do not break a run
    doReset();
    for (int k = 0; k < 4; k++) pushSample(8'h33);
    @(negedge clk); sampleData = 8'h44;
    repeat (3) @(negedge clk);
    check("R10 no fault before gap", 32'(errFlag), 0);
    pushSample(8'h33);
    check("R10 run across idle gap", 32'(errCode), 32'h2C);

    // R5: startup completion
    doReset();
    startup(1023);
    check("R5 startupDone before last", 32'(startupDone), 0);
    check("R5 healthy before last", 32'(healthy), 0);
    pushSample(good(1023));
    check("R5 startupDone", 32'(startupDone), 1);
    check("R5 healthy", 32'(healthy), 1);

    // R6: failure in operation
    for (int k = 0; k < 4; k++) pushSample(8'h33);
    check("R6 healthy below cutoff", 32'(healthy), 1);
    pushSample(8'h33);
    check("R6 code in operation", 32'(errCode), 32'h2C);
    check("R6 healthy drops", 32'(healthy), 0);
    check("R6 startupDone kept", 32'(startupDone), 1);

    // R7: inputs ignored in fault
    pushWord(32'hAAAA); pushWord(32'hAAAA);
    pushSample(8'h01); pushSample(8'h01);
    check("R7 code kept", 32'(errCode), 32'h2C);
    check("R7 fault kept", 32'(errFlag), 1);

    // R8: reset clears, startup needed again
    doReset();
    check("R8 fault cleared", 32'(errFlag), 0);
    check("R8 startupDone cleared", 32'(startupDone), 0);
    startup(1023);
    check("R8 not healthy before full startup", 32'(healthy), 0);
    pushSample(good(1023));
    check("R8 healthy again", 32'(healthy), 1);

    // R4: first word after reset has no predecessor
    pushWord(32'hCAFE0001);
    check("R4 word accepted", 32'(errFlag), 0);
    doReset();
    pushWord(32'hCAFE0001);
    check("R4 first word after reset", 32'(errFlag), 0);
    pushWord(32'hCAFE0001);
    check("R4 repeated word", 32'(errCode), 32'h1E);

    // R9: priorities
    doReset();
    pushWord(32'h77);
    for (int k = 0; k < 4; k++) pushSample(8'h33);
    pushBoth(8'h33, 32'h77);
    check("R9 run over word", 32'(errCode), 32'h2C);

    doReset();
    pushSample(8'h01);
    for (int k = 0; k < 8; k++) begin pushSample(8'h80 | 8'(k)); pushSample(8'h01); end
    for (int k = 0; k < 4; k++) pushSample(8'h01);
    check("R9 run over proportion", 32'(errCode), 32'h2C);

    doReset();
    pushSample(8'h01);
    for (int k = 0; k < 11; k++) begin pushSample(8'h80 | 8'(k)); pushSample(8'h01); end
    pushWord(32'h55);
    pushSample(8'h8B);
    pushBoth(8'h01, 32'h55);
    check("R9 proportion over word", 32'(errCode), 32'h2D);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule